// File: doc/BRIEF.md
# Compare and Conditional-Move Unit

This unit executes the less-than compare and the conditional-move operations of a 32-bit RISC execute stage. Each cycle it receives the primary opcode, the function code, the two source register values and the 16-bit immediate field. From these it produces a registered result word and a registered write-enable for the destination register.

The compare operations return 1 or 0 and always write. A single comparator does both signed and unsigned compares. Its second operand is either the second register or the sign-extended immediate. The conditional moves pass the first source through. When their condition on the second source fails, they drop the write-enable, so the register file keeps its old contents. Any other encoding yields zero with no write.

Top module: `cmpmov_unit`

## Requirements
- R1: A synchronous active-high reset forces `result` to 0 and `wr_en` to 0.
- R2: Every operation is registered: the inputs present at a rising clock edge show up on `result` and `wr_en` right after that edge, one result per cycle with no stalls.
- R3: With `opcode` 0x00 and `funct` 0x2a, `wr_en` is 1 and `result` is 1 when `rs_val` is less than `rt_val` as two's-complement numbers, else 0 (for example 1 against 0xFFFFFFFF gives 0).
- R4: With `opcode` 0x00 and `funct` 0x2b, the same holds with an unsigned comparison (1 against 0xFFFFFFFF gives 1).
- R5: With `opcode` 0x0a, `wr_en` is 1 and `result` is 1 when `rs_val` is less than the sign-extended `imm` as signed numbers, else 0. `funct` is ignored.
- R6: With `opcode` 0x0b, the immediate is still sign-extended to 32 bits and the comparison is unsigned (`imm` 0xFFFF compares as 0xFFFFFFFF). `funct` is ignored.
- R7: With `opcode` 0x00 and `funct` 0x0a, when `rt_val` is zero, `wr_en` is 1 and `result` equals `rs_val`.
- R8: With `opcode` 0x00 and `funct` 0x0b, when `rt_val` is nonzero, `wr_en` is 1 and `result` equals `rs_val`.
- R9: A conditional move whose condition fails (funct 0x0a with `rt_val` nonzero, or funct 0x0b with `rt_val` zero) gives `wr_en` 0 and `result` 0.
- R10: Any other opcode, or opcode 0x00 with any other function code, gives `wr_en` 0 and `result` 0.
- R11: A compare result has bits 31..1 equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code, used when opcode is 0x00 |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm | input | 16 | Immediate field, sign-extended inside |
| result | output | 32 | Registered result word |
| wr_en | output | 1 | Registered destination write-enable |

## Verification
Every result and write-enable is due exactly one rising edge after its inputs are applied. The bench drives each new operation on a falling edge. On the next falling edge it compares the outputs against a behavioural model evaluated on the operation driven one cycle earlier, so a new operation can be issued every cycle. Reset is checked the same way, with the zero state expected one edge after `rst` is raised.

// File: rtl/cmpmov_pkg.sv
package cmpmov_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_REG       = 6'h00;
  localparam logic [OP_W-1:0] OPC_LESS_IMM  = 6'h0a;
  localparam logic [OP_W-1:0] OPC_LESS_IMMU = 6'h0b;

  localparam logic [OP_W-1:0] FN_MOV_IF_ZERO = 6'h0a;
  localparam logic [OP_W-1:0] FN_MOV_IF_NZ   = 6'h0b;
  localparam logic [OP_W-1:0] FN_LESS_S      = 6'h2a;
  localparam logic [OP_W-1:0] FN_LESS_U      = 6'h2b;

  typedef enum logic [1:0] {
    OPK_NONE,
    OPK_LESS,
    OPK_MOVZ,
    OPK_MOVN
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_imm;
    logic     is_signed;
  } dec_ctl_t;
endpackage

// File: rtl/cmpmov_decode.sv
module cmpmov_decode
  import cmpmov_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [OP_W-1:0] funct,
  output dec_ctl_t        ctl
);
  always_comb begin
    ctl = '{kind: OPK_NONE, use_imm: 1'b0, is_signed: 1'b0};
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_LESS_S:      ctl = '{kind: OPK_LESS, use_imm: 1'b0, is_signed: 1'b1};
          FN_LESS_U:      ctl = '{kind: OPK_LESS, use_imm: 1'b0, is_signed: 1'b0};
          FN_MOV_IF_ZERO: ctl.kind = OPK_MOVZ;
          FN_MOV_IF_NZ:   ctl.kind = OPK_MOVN;
          default:        ctl.kind = OPK_NONE;
        endcase
      end
      OPC_LESS_IMM:  ctl = '{kind: OPK_LESS, use_imm: 1'b1, is_signed: 1'b1};
      OPC_LESS_IMMU: ctl = '{kind: OPK_LESS, use_imm: 1'b1, is_signed: 1'b0};
      default:       ctl.kind = OPK_NONE;
    endcase
  end
endmodule

// File: rtl/cmpmov_compare.sv
module cmpmov_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  output logic         lt
);
  // One extra top bit turns both flavours into a single signed compare.
  logic signed [W:0] a_x;
  logic signed [W:0] b_x;

  assign a_x = {is_signed & a[W-1], a};
  assign b_x = {is_signed & b[W-1], b};
  assign lt  = (a_x < b_x);
endmodule

// File: rtl/cmpmov_unit.sv
module cmpmov_unit
  import cmpmov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [OP_W-1:0]   funct,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              wr_en
);
  localparam int EXT_W = DATA_W - IMM_W;

  dec_ctl_t          ctl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] cmp_b;
  logic              less;
  logic              rt_zero;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_wr;

  cmpmov_decode u_decode (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign cmp_b   = ctl.use_imm ? imm_ext : rt_val;
  assign rt_zero = (rt_val == '0);

  cmpmov_compare #(.W(DATA_W)) u_compare (
    .a         (rs_val),
    .b         (cmp_b),
    .is_signed (ctl.is_signed),
    .lt        (less)
  );

  always_comb begin
    nxt_result = '0;
    nxt_wr     = 1'b0;
    unique case (ctl.kind)
      OPK_LESS: begin
        nxt_result = {{(DATA_W-1){1'b0}}, less};
        nxt_wr     = 1'b1;
      end
      OPK_MOVZ: begin
        nxt_wr     = rt_zero;
        nxt_result = rt_zero ? rs_val : '0;
      end
      OPK_MOVN: begin
        nxt_wr     = !rt_zero;
        nxt_result = rt_zero ? '0 : rs_val;
      end
      default: begin
        nxt_result = '0;
        nxt_wr     = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr_en  <= 1'b0;
    end else begin
      result <= nxt_result;
      wr_en  <= nxt_wr;
    end
  end

  AST_LESS_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_REG && (funct == FN_LESS_S || funct == FN_LESS_U))
    |=> (wr_en && result[DATA_W-1:1] == '0)); // R11

  AST_MOVZ_PASS: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_REG && funct == FN_MOV_IF_ZERO && rt_val == '0)
    |=> (wr_en && result == $past(rs_val))); // R7

  AST_MOVN_PASS: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_REG && funct == FN_MOV_IF_NZ && rt_val != '0)
    |=> (wr_en && result == $past(rs_val))); // R8

  AST_MOV_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_REG &&
     ((funct == FN_MOV_IF_ZERO && rt_val != '0) || (funct == FN_MOV_IF_NZ && rt_val == '0)))
    |=> (!wr_en && result == '0)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_REG && opcode != OPC_LESS_IMM && opcode != OPC_LESS_IMMU)
    |=> (!wr_en && result == '0)); // R10
endmodule

// File: tb/cmpmov_unit_bench.sv
module cmpmov_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        wr_en;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [32:0] pend_exp;
  string       pend_tag;
  bit          pend_valid = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  cmpmov_unit u_cmpmov_unit (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
    .result(result), .wr_en(wr_en)
  );

  // Behavioural reference: {write, value}
  function automatic logic [32:0] model(input logic [5:0] op, input logic [5:0] fn,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] im);
    longint sa, sb, si, ua, ub, ui;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(im));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    ui = si & 64'h0000_0000_FFFF_FFFF;
    if (op == 6'h00 && fn == 6'h2a) return {1'b1, 31'd0, (sa < sb)};
    if (op == 6'h00 && fn == 6'h2b) return {1'b1, 31'd0, (ua < ub)};
    if (op == 6'h0a)                return {1'b1, 31'd0, (sa < si)};
    if (op == 6'h0b)                return {1'b1, 31'd0, (ua < ui)};
    if (op == 6'h00 && fn == 6'h0a) return (b == 0) ? {1'b1, a} : 33'd0;
    if (op == 6'h00 && fn == 6'h0b) return (b != 0) ? {1'b1, a} : 33'd0;
    return 33'd0;
  endfunction

  task automatic check_pending();
    if (pend_valid) begin
      total++;
      if ({wr_en, result} !== pend_exp) begin
        bad++;
        $display("FAIL %s: got wr=%0b res=%h, expected wr=%0b res=%h",
                 pend_tag, wr_en, result, pend_exp[32], pend_exp[31:0]);
      end
    end
  endtask

  // Each call: check the previous op's output, then drive a new op.
  task automatic issue(input logic [5:0] op, input logic [5:0] fn, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input string tag);
    @(negedge clk);
    check_pending();
    rst = 1'b0;
    opcode = op; funct = fn; rs_val = a; rt_val = b; imm = im;
    pend_exp = model(op, fn, a, b, im);
    pend_tag = tag;
    pend_valid = 1'b1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    check_pending();
    rst = 1'b1;
    opcode = 6'h00; funct = 6'h0a; rs_val = 32'hDEAD_BEEF; rt_val = 32'd0; imm = 16'h7FFF;
    pend_exp = 33'd0;
    pend_tag = "R1 reset";
    pend_valid = 1'b1;
  endtask

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        total++; bad++;
        $display("FAIL watchdog: got cycles=%0d, expected done before 20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] ops [6];
    logic [5:0] fns [6];
    ops = '{6'h00, 6'h00, 6'h0a, 6'h0b, 6'h00, 6'h08};
    fns = '{6'h2a, 6'h2b, 6'h11, 6'h3f, 6'h0a, 6'h20};

    apply_reset();
    issue(6'h00, 6'h2a, 32'd1, 32'hFFFF_FFFF, 16'h0, "R3 1 vs -1 signed");
    issue(6'h00, 6'h2b, 32'd1, 32'hFFFF_FFFF, 16'h0, "R4 1 vs max unsigned");
    issue(6'h00, 6'h2a, 32'hFFFF_FFFB, 32'd3, 16'h0, "R3 -5 vs 3");
    issue(6'h00, 6'h2b, 32'h8000_0000, 32'h8000_0000, 16'h0, "R4 equal");
    issue(6'h0a, 6'h2b, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, "R5 -2 vs imm -1");
    issue(6'h0a, 6'h00, 32'd100, 32'd7, 16'h7FFF, "R5 100 vs imm 0x7fff");
    issue(6'h0b, 6'h0a, 32'd5, 32'd0, 16'hFFFF, "R6 5 vs sext 0xffff");
    issue(6'h0b, 6'h00, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, "R6 max vs sext 0xffff");
    issue(6'h0b, 6'h00, 32'h0000_8000, 32'd0, 16'h7FFF, "R6 positive imm");
    issue(6'h00, 6'h0a, 32'hCAFE_0001, 32'd0, 16'h0, "R7 move when zero");
    issue(6'h00, 6'h0a, 32'hCAFE_0002, 32'd3, 16'h0, "R9 move-if-zero fails");
    issue(6'h00, 6'h0b, 32'hCAFE_0003, 32'd3, 16'h0, "R8 move when nonzero");
    issue(6'h00, 6'h0b, 32'hCAFE_0004, 32'd0, 16'h0, "R9 move-if-nonzero fails");
    issue(6'h00, 6'h20, 32'hFFFF_FFFF, 32'd1, 16'hFFFF, "R10 unknown funct");
    issue(6'h08, 6'h2a, 32'd0, 32'd5, 16'h1234, "R10 unknown opcode");
    issue(6'h00, 6'h2a, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "R11 signed extremes");
    apply_reset();
    issue(6'h00, 6'h0b, 32'h0000_00AA, 32'd9, 16'h0, "R2 after reset");
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [31:0] a, b;
      step_lfsr(); k = int'(lfsr % 6);
      step_lfsr(); a = lfsr;
      step_lfsr(); b = (lfsr[3:0] == 4'd0) ? 32'd0 : lfsr;
      step_lfsr();
      issue(ops[k], fns[k], a, b, lfsr[15:0], "R2 back-to-back mix");
    end
    @(negedge clk);
    check_pending();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule